// File: doc/BRIEF.md
# Burst Memory Command Issuer

This block sits in front of the client port of a burst-oriented memory controller. Read requests and write requests arrive on two separate valid/ready streams, and each stream has a small queue behind it. Every clock cycle the block picks at most one request and presents it to the controller as a command. A command is a single-cycle enable strobe that comes with a 2-bit command code, an address and a bank. A write also carries its data and byte-mask word in the same cycle as its command.

The `burst8` pin selects between two modes. In four-word mode a write needs one data beat. In eight-word mode a write needs a second data beat in the cycle after its command. No write command may go out in that cycle, but the block uses the free command slot for the oldest queued read. When a slot is free and both queues hold work, the write goes first. The mode is sampled when each write issues.

Back-pressure: a request transfers only on a rising edge where its valid and ready are both high. Ready is low while that queue holds `DEPTH` entries. A request is taken from its queue only in the cycle its command is issued. Each request costs at least two cycles from acceptance to command: one to enter the queue and one to reach the registered outputs.

Top module: `burst_cmd_issuer`

## Requirements
- R1: While synchronous reset is high, `cmd_en` and `wdata_en` are low and both request ready outputs are high.
- R2: A read command has code 2'b01 and a write command has code 2'b00. The address and bank are valid in the cycle `cmd_en` is high. Each accepted request produces exactly one command, in acceptance order within its own queue.
- R3: A cycle carries at most one command. A read command never shares its cycle with the first data beat of a write.
- R4: In a write command cycle, `wdata_en` is high and `wdata`/`wmask` carry the request's first data and mask words.
- R5: With `burst8` high when a write issues, the next cycle has `wdata_en` high with the request's second data and mask words, and no write command.
- R6: In that second-beat cycle, if a read is queued, the oldest read issues.
- R7: In a slot that can carry a write, a queued write is issued before any queued read.
- R8: With `burst8` low, a write uses one data beat, and queued writes issue in consecutive cycles.
- R9: In a cycle with no command and no second beat, `cmd_en` and `wdata_en` are low, and `wdata` and `wmask` are zero.
- R10: A queue's ready output is low while that queue holds DEPTH entries. A request offered while ready is low is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| burst8 | input | 1 | 1 = eight-word burst mode (two write beats), 0 = four-word mode |
| wr_in_valid | input | 1 | Write request valid |
| wr_in_ready | output | 1 | Write queue can take a request |
| wr_in_addr | input | AW | Write address |
| wr_in_bank | input | BW | Write bank |
| wr_in_data0 | input | DW | First write data word |
| wr_in_mask0 | input | MW | First write mask word |
| wr_in_data1 | input | DW | Second write data word (eight-word mode) |
| wr_in_mask1 | input | MW | Second write mask word (eight-word mode) |
| rd_in_valid | input | 1 | Read request valid |
| rd_in_ready | output | 1 | Read queue can take a request |
| rd_in_addr | input | AW | Read address |
| rd_in_bank | input | BW | Read bank |
| cmd_en | output | 1 | One-cycle command strobe |
| cmd_code | output | 2 | 2'b00 write, 2'b01 read |
| cmd_addr | output | AW | Command address |
| cmd_bank | output | BW | Command bank |
| wdata_en | output | 1 | Write data beat valid |
| wdata | output | DW | Write data word |
| wmask | output | MW | Write mask word |

## Verification
The bench sweeps both modes against every mix of write and read offer rates. It goes after the second-beat cycle first. A design that lets a write issue there sends two writes one cycle apart in eight-word mode. A design that leaves the gap empty delays a pending read by a cycle. A write and a read arriving together check the priority rule: a design that favours reads shifts the write behind the read. Saturated write traffic in eight-word mode fills the queue, and the requests the bench offers while ready is low carry corrupted fields, so a design that takes them issues wrong addresses or data. Idle cycles are checked for stray data strobes and non-zero data left on the bus.

// File: rtl/bci_pkg.sv
`timescale 1ns/1ps
package bci_pkg;
  localparam logic [1:0] CMD_WR = 2'b00;
  localparam logic [1:0] CMD_RD = 2'b01;
endpackage

// File: rtl/bci_fifo.sv
`timescale 1ns/1ps
module bci_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             pop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             push;

  assign in_ready  = (cnt != FULL);
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R10: the scheduler only takes from a queue that holds something
  a_r10_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));
  // R10: a full queue with nothing leaving stays full (no request slips in)
  a_r10_full_holds: assert property (@(posedge clk) disable iff (rst)
    ((cnt == FULL) && !pop) |=> (cnt == FULL));
endmodule

// File: rtl/bci_sched.sv
`timescale 1ns/1ps
module bci_sched
  import bci_pkg::*;
#(
  parameter int AW = 12,
  parameter int BW = 3,
  parameter int DW = 16,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          burst8,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_bank,
  input  logic [DW-1:0] wr_d0,
  input  logic [MW-1:0] wr_m0,
  input  logic [DW-1:0] wr_d1,
  input  logic [MW-1:0] wr_m1,
  output logic          wr_pop,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic [BW-1:0] rd_bank,
  output logic          rd_pop,
  output logic          cmd_en,
  output logic [1:0]    cmd_code,
  output logic [AW-1:0] cmd_addr,
  output logic [BW-1:0] cmd_bank,
  output logic          wdata_en,
  output logic [DW-1:0] wdata,
  output logic [MW-1:0] wmask
);
  logic          hold_q;      // second write beat goes out next cycle
  logic [DW-1:0] beat2_d_q;
  logic [MW-1:0] beat2_m_q;
  logic          take_wr, take_rd;

  always_comb begin
    take_wr = wr_valid && !hold_q;
    take_rd = rd_valid && !take_wr;
  end

  assign wr_pop = take_wr;
  assign rd_pop = take_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_en    <= 1'b0;
      cmd_code  <= CMD_RD;
      cmd_addr  <= '0;
      cmd_bank  <= '0;
      wdata_en  <= 1'b0;
      wdata     <= '0;
      wmask     <= '0;
      hold_q    <= 1'b0;
      beat2_d_q <= '0;
      beat2_m_q <= '0;
    end else begin
      cmd_en   <= take_wr || take_rd;
      cmd_code <= take_wr ? CMD_WR : CMD_RD;
      if (take_wr) begin
        cmd_addr <= wr_addr;
        cmd_bank <= wr_bank;
      end else if (take_rd) begin
        cmd_addr <= rd_addr;
        cmd_bank <= rd_bank;
      end else begin
        cmd_addr <= '0;
        cmd_bank <= '0;
      end

      if (hold_q) begin
        wdata_en <= 1'b1;
        wdata    <= beat2_d_q;
        wmask    <= beat2_m_q;
        hold_q   <= 1'b0;
      end else if (take_wr) begin
        wdata_en  <= 1'b1;
        wdata     <= wr_d0;
        wmask     <= wr_m0;
        hold_q    <= burst8;
        beat2_d_q <= wr_d1;
        beat2_m_q <= wr_m1;
      end else begin
        wdata_en <= 1'b0;
        wdata    <= '0;
        wmask    <= '0;
      end
    end
  end

  // R2: only the two defined codes go out with the strobe
  a_r2_code_legal: assert property (@(posedge clk) disable iff (rst)
    cmd_en |-> ((cmd_code == CMD_WR) || (cmd_code == CMD_RD)));
  // R4: a write command always carries a data beat
  a_r4_write_beat: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && (cmd_code == CMD_WR)) |-> wdata_en);
  // R5: second beat follows, with no write command in that slot
  a_r5_gap_no_write: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> (wdata_en && !(cmd_en && (cmd_code == CMD_WR))));
  // R3: data alongside a read can only be a second beat
  a_r3_read_no_first_beat: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && (cmd_code == CMD_RD) && wdata_en) |-> $past(hold_q));
  // R6: a queued read fills the gap
  a_r6_gap_read: assert property (@(posedge clk) disable iff (rst)
    (hold_q && rd_valid) |=> (cmd_en && (cmd_code == CMD_RD)));
  // R7: a free slot with a queued write carries that write
  a_r7_write_first: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && wr_valid) |=> (cmd_en && (cmd_code == CMD_WR)));
  // R9: no data strobe without a command or a pending second beat
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!cmd_en && !$past(hold_q)) |-> !wdata_en);
endmodule

// File: rtl/burst_cmd_issuer.sv
`timescale 1ns/1ps
module burst_cmd_issuer #(
  parameter int AW    = 12,
  parameter int BW    = 3,
  parameter int DW    = 16,
  parameter int MW    = DW / 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          burst8,
  input  logic          wr_in_valid,
  output logic          wr_in_ready,
  input  logic [AW-1:0] wr_in_addr,
  input  logic [BW-1:0] wr_in_bank,
  input  logic [DW-1:0] wr_in_data0,
  input  logic [MW-1:0] wr_in_mask0,
  input  logic [DW-1:0] wr_in_data1,
  input  logic [MW-1:0] wr_in_mask1,
  input  logic          rd_in_valid,
  output logic          rd_in_ready,
  input  logic [AW-1:0] rd_in_addr,
  input  logic [BW-1:0] rd_in_bank,
  output logic          cmd_en,
  output logic [1:0]    cmd_code,
  output logic [AW-1:0] cmd_addr,
  output logic [BW-1:0] cmd_bank,
  output logic          wdata_en,
  output logic [DW-1:0] wdata,
  output logic [MW-1:0] wmask
);
  localparam int WW = AW + BW + 2 * DW + 2 * MW;
  localparam int RW = AW + BW;

  logic [WW-1:0] wq_head;
  logic [RW-1:0] rq_head;
  logic          wq_valid, rq_valid, wq_pop, rq_pop;
  logic [AW-1:0] w_addr, r_addr;
  logic [BW-1:0] w_bank, r_bank;
  logic [DW-1:0] w_d0, w_d1;
  logic [MW-1:0] w_m0, w_m1;

  bci_fifo #(.WIDTH(WW), .DEPTH(DEPTH)) u_wq (
    .clk(clk), .rst(rst),
    .in_valid(wr_in_valid), .in_ready(wr_in_ready),
    .in_data({wr_in_addr, wr_in_bank, wr_in_data0, wr_in_mask0, wr_in_data1, wr_in_mask1}),
    .out_valid(wq_valid), .out_data(wq_head), .pop(wq_pop)
  );

  bci_fifo #(.WIDTH(RW), .DEPTH(DEPTH)) u_rq (
    .clk(clk), .rst(rst),
    .in_valid(rd_in_valid), .in_ready(rd_in_ready),
    .in_data({rd_in_addr, rd_in_bank}),
    .out_valid(rq_valid), .out_data(rq_head), .pop(rq_pop)
  );

  assign {w_addr, w_bank, w_d0, w_m0, w_d1, w_m1} = wq_head;
  assign {r_addr, r_bank} = rq_head;

  bci_sched #(.AW(AW), .BW(BW), .DW(DW), .MW(MW)) u_sched (
    .clk(clk), .rst(rst), .burst8(burst8),
    .wr_valid(wq_valid), .wr_addr(w_addr), .wr_bank(w_bank),
    .wr_d0(w_d0), .wr_m0(w_m0), .wr_d1(w_d1), .wr_m1(w_m1), .wr_pop(wq_pop),
    .rd_valid(rq_valid), .rd_addr(r_addr), .rd_bank(r_bank), .rd_pop(rq_pop),
    .cmd_en(cmd_en), .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_bank(cmd_bank),
    .wdata_en(wdata_en), .wdata(wdata), .wmask(wmask)
  );
endmodule

// File: tb/tb_burst_cmd_issuer.sv
`timescale 1ns/1ps
module tb_burst_cmd_issuer;
  localparam int AW = 12, BW = 3, DW = 16, MW = 2, DEPTH = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, burst8 = 1'b0;
  logic wr_in_valid = 1'b0, rd_in_valid = 1'b0;
  logic wr_in_ready, rd_in_ready;
  logic [AW-1:0] wr_in_addr = '0, rd_in_addr = '0;
  logic [BW-1:0] wr_in_bank = '0, rd_in_bank = '0;
  logic [DW-1:0] wr_in_data0 = '0, wr_in_data1 = '0;
  logic [MW-1:0] wr_in_mask0 = '0, wr_in_mask1 = '0;
  logic cmd_en, wdata_en;
  logic [1:0] cmd_code;
  logic [AW-1:0] cmd_addr;
  logic [BW-1:0] cmd_bank;
  logic [DW-1:0] wdata;
  logic [MW-1:0] wmask;

  burst_cmd_issuer #(.AW(AW), .BW(BW), .DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .burst8(burst8),
    .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready),
    .wr_in_addr(wr_in_addr), .wr_in_bank(wr_in_bank),
    .wr_in_data0(wr_in_data0), .wr_in_mask0(wr_in_mask0),
    .wr_in_data1(wr_in_data1), .wr_in_mask1(wr_in_mask1),
    .rd_in_valid(rd_in_valid), .rd_in_ready(rd_in_ready),
    .rd_in_addr(rd_in_addr), .rd_in_bank(rd_in_bank),
    .cmd_en(cmd_en), .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_bank(cmd_bank),
    .wdata_en(wdata_en), .wdata(wdata), .wmask(wmask)
  );

  int total = 0, bad = 0, cyc = 0, base = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [AW-1:0] wa(int k); return AW'(k * 29 + 3); endfunction
  function automatic logic [BW-1:0] wb(int k); return BW'(k); endfunction
  function automatic logic [DW-1:0] wd0(int k); return DW'(k * 4369 + 17); endfunction
  function automatic logic [DW-1:0] wd1(int k); return DW'(k * 257 + 40000); endfunction
  function automatic logic [MW-1:0] wm0(int k); return MW'(k); endfunction
  function automatic logic [MW-1:0] wm1(int k); return MW'(k + 2); endfunction
  function automatic logic [AW-1:0] ra(int k); return AW'(k * 53 + 11); endfunction
  function automatic logic [BW-1:0] rb(int k); return BW'(k + 5); endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor state
  bit mon_on = 0, beat2_due = 0;
  int beat2_k = 0, acc_w = 0, acc_r = 0, exp_w = 0, exp_r = 0;
  int wr_at [64];
  int rd_at [64];
  bit saw_full = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      bit nb2;
      nb2 = 0;
      if (!wr_in_ready) saw_full = 1;
      if (beat2_due) begin
        chk(wdata_en == 1'b1, "R5", "second beat enable", wdata_en, 1);
        chk(wdata == wd1(beat2_k + base), "R5", "second beat data", wdata, wd1(beat2_k + base));
        chk(wmask == wm1(beat2_k + base), "R5", "second beat mask", wmask, wm1(beat2_k + base));
        chk(!(cmd_en && cmd_code == 2'b00), "R5", "write in gap", cmd_code, 1);
      end
      if (cmd_en) begin
        if (cmd_code == 2'b00) begin
          chk(exp_w < acc_w, "R2", "unexpected write", exp_w, acc_w);
          chk(cmd_addr == wa(exp_w + base), "R2", "write addr", cmd_addr, wa(exp_w + base));
          chk(cmd_bank == wb(exp_w + base), "R2", "write bank", cmd_bank, wb(exp_w + base));
          chk(wdata_en == 1'b1, "R4", "write data enable", wdata_en, 1);
          chk(wdata == wd0(exp_w + base), "R4", "write data", wdata, wd0(exp_w + base));
          chk(wmask == wm0(exp_w + base), "R4", "write mask", wmask, wm0(exp_w + base));
          if (exp_w < 64) wr_at[exp_w] = cyc;
          nb2 = burst8;
          beat2_k = exp_w;
          exp_w++;
        end else if (cmd_code == 2'b01) begin
          chk(exp_r < acc_r, "R2", "unexpected read", exp_r, acc_r);
          chk(cmd_addr == ra(exp_r + base), "R2", "read addr", cmd_addr, ra(exp_r + base));
          chk(cmd_bank == rb(exp_r + base), "R2", "read bank", cmd_bank, rb(exp_r + base));
          if (!beat2_due) chk(wdata_en == 1'b0, "R3", "first beat with read", wdata_en, 0);
          if (exp_r < 64) rd_at[exp_r] = cyc;
          exp_r++;
        end else begin
          chk(0, "R2", "command code", cmd_code, 0);
        end
      end else if (!beat2_due) begin
        chk(wdata_en == 1'b0 && wdata == '0 && wmask == '0, "R9", "idle bus",
            {wdata_en, wdata, wmask}, 0);
      end
      beat2_due = nb2;
    end
  end

  task automatic do_reset();
    mon_on = 0;
    wr_in_valid = 0;
    rd_in_valid = 0;
    rst = 1;
    repeat (2) @(negedge clk);
    chk(cmd_en == 1'b0, "R1", "cmd_en in reset", cmd_en, 0);
    chk(wdata_en == 1'b0, "R1", "wdata_en in reset", wdata_en, 0);
    chk(wr_in_ready && rd_in_ready, "R1", "ready in reset", {wr_in_ready, rd_in_ready}, 3);
    rst = 0;
    beat2_due = 0; acc_w = 0; acc_r = 0; exp_w = 0; exp_r = 0; saw_full = 0;
    mon_on = 1;
  endtask

  task automatic offer_wr(input int k);
    wr_in_valid = 1;
    if (wr_in_ready) begin
      wr_in_addr = wa(k + base); wr_in_bank = wb(k + base);
      wr_in_data0 = wd0(k + base); wr_in_mask0 = wm0(k + base);
      wr_in_data1 = wd1(k + base); wr_in_mask1 = wm1(k + base);
      acc_w++;
    end else begin
      wr_in_addr = ~wa(k + base); wr_in_bank = ~wb(k + base);
      wr_in_data0 = ~wd0(k + base); wr_in_mask0 = ~wm0(k + base);
      wr_in_data1 = ~wd1(k + base); wr_in_mask1 = ~wm1(k + base);
    end
  endtask

  task automatic offer_rd(input int k);
    rd_in_valid = 1;
    if (rd_in_ready) begin
      rd_in_addr = ra(k + base); rd_in_bank = rb(k + base);
      acc_r++;
    end else begin
      rd_in_addr = ~ra(k + base); rd_in_bank = ~rb(k + base);
    end
  endtask

  task automatic drain_and_count(input int nw, input int nr);
    @(negedge clk);
    wr_in_valid = 0;
    rd_in_valid = 0;
    repeat (40) @(negedge clk);
    chk(exp_w == nw, "R2", "writes issued", exp_w, nw);
    chk(exp_r == nr, "R2", "reads issued", exp_r, nr);
  endtask

  task automatic traffic(input bit mode, input int wp, input int rp, input int nw, input int nr);
    burst8 = mode;
    base += 100;
    do_reset();
    for (int t = 0; t < 3000 && (acc_w < nw || acc_r < nr); t++) begin
      @(negedge clk);
      if (acc_w < nw && (t % wp) == 0) offer_wr(acc_w); else wr_in_valid = 0;
      if (acc_r < nr && (t % rp) == 0) offer_rd(acc_r); else rd_in_valid = 0;
    end
    drain_and_count(nw, nr);
    if (mode && wp == 1) chk(saw_full, "R10", "write queue filled", saw_full, 1);
  endtask

  task automatic ordering(input bit mode);
    burst8 = mode;
    base += 100;
    do_reset();
    @(negedge clk);
    offer_wr(0);
    offer_rd(0);
    @(negedge clk);
    offer_wr(1);
    rd_in_valid = 0;
    drain_and_count(2, 1);
    chk(rd_at[0] > wr_at[0], "R7", "write before read", rd_at[0] - wr_at[0], 1);
    if (mode) begin
      chk(rd_at[0] - wr_at[0] == 1, "R6", "read fills gap", rd_at[0] - wr_at[0], 1);
      chk(wr_at[1] - wr_at[0] == 2, "R5", "write spacing", wr_at[1] - wr_at[0], 2);
    end else begin
      chk(wr_at[1] - wr_at[0] == 1, "R8", "back-to-back writes", wr_at[1] - wr_at[0], 1);
      chk(rd_at[0] - wr_at[0] == 2, "R7", "read after both writes", rd_at[0] - wr_at[0], 2);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  initial begin
    ordering(1'b0);
    ordering(1'b1);
    for (int m = 0; m < 2; m++)
      for (int wp = 1; wp <= 3; wp++)
        for (int rp = 1; rp <= 3; rp++)
          traffic(m[0], wp, rp, 20, 20);
    traffic(1'b1, 1, 1, 30, 0);
    traffic(1'b0, 1, 1, 0, 30);
    summary();
  end
endmodule